// File: doc/BRIEF.md
# Batched Pointer-Chasing Lookup Engine

This block searches singly linked lists held in word-addressed memory. A batch of up to `BATCH_MAX` independent lookups is loaded into a command buffer. Each command holds a search key and a start location. The location is either a slot in a bucket table, whose word holds the address of the first node, or the address of a node. A scheduler hands the queued commands to several walker engines. Each engine follows its own chain one node at a time and compares each stored key with the search key. The chain ends on a match, on a null link, or when the hop limit runs out.

A node occupies three consecutive words: the key at offset 0, the value at offset 1 and the next-node address at offset 2. Address 0 stands for null. All engines share one read port. Each read request carries the engine number as a tag, so responses may come back in any order. Results are collected into a result buffer. They leave the block only after every command of the batch has finished, and they leave in command order. A new batch is accepted only after the last result has been taken.

The controller cycles through FILL (accepting commands), RUN (dispatching and collecting) and DRAIN (streaming results). FILL goes to RUN when the closing command is accepted. RUN goes to DRAIN once the number of finished commands equals the number accepted. DRAIN goes back to FILL when the final result is handshaken. Each walker has these states:
- W_IDLE, which moves to W_HEAD_RD, to W_KEY_RD, or straight to W_DONE for a null pointer.
- W_HEAD_RD and W_HEAD_WT.
- W_KEY_RD and W_KEY_WT, which move on to the value read on a match and to the link read otherwise.
- W_VAL_RD and W_VAL_WT.
- W_NXT_RD and W_NXT_WT, which return to W_KEY_RD or end in W_DONE.
- W_DONE, which returns to W_IDLE when the controller acknowledges the result.

Top module: `chain_lookup_top`

## Requirements
- R1: `cmd_ready` is high in FILL. The batch closes when a command with `cmd_last`=1 is accepted, or when the `BATCH_MAX`-th command is accepted, whichever comes first.
- R2: `cmd_ready` stays low from the cycle after the batch closes until the cycle after the final result is accepted.
- R3: A command with `cmd_use_ptr`=0 first reads address `BUCKET_BASE + cmd_loc`. The low `ADDR_W` bits of that word are the first node address, and a value of 0 gives a miss.
- R4: A command with `cmd_use_ptr`=1 starts at node `cmd_loc`. If `cmd_loc` is 0 it ends in a miss without issuing any memory read.
- R5: A node at address p has its key at p, its value at p+1 and its next address at p+2. When the key matches, the result is status 1 (hit), the address p and the value word.
- R6: A null next address ends the walk with status 0 (miss), and both the address and the value are 0.
- R7: A walk that has visited `MAX_HOPS` nodes without a match and reads a non-null link ends with status 2 (error), with address and value 0. A match or null link at the `MAX_HOPS`-th node still gives a hit or a miss.
- R8: Each engine has at most one read outstanding. `mem_req_tag` is the engine number, and a response with a given tag is delivered only to that engine, whatever the order of arrival.
- R9: Results appear only after every command in the batch has finished and no read is outstanding. `res_idx` runs 0..n-1 in command order, `res_last` marks index n-1, and the outputs hold steady while `res_ready` is low.
- R10: A memory request keeps `mem_req_valid`, `mem_req_addr` and `mem_req_tag` steady until `mem_req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted (FILL only) |
| cmd_key | input | DATA_W | Search key |
| cmd_use_ptr | input | 1 | 1: loc is a node address; 0: loc is a bucket index |
| cmd_loc | input | ADDR_W | Bucket index or node address |
| cmd_last | input | 1 | Closes the batch |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_tag | output | TAG_W | Engine number |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_tag | input | TAG_W | Engine number of returned data |
| mem_rsp_data | input | DATA_W | Read data |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Result accepted |
| res_idx | output | CIDX_W | Command index within batch |
| res_status | output | 2 | 0 miss, 1 hit, 2 error |
| res_addr | output | ADDR_W | Matching node address or 0 |
| res_value | output | DATA_W | Matching value or 0 |
| res_last | output | 1 | Final result of batch |

## Verification
The chains are built in the bench: short random bucket chains, one empty bucket, a three-node loop and a chain exactly `MAX_HOPS` long. Directed single-command batches separate the three endings and the two start modes. The loop shows the error ending and the long chain its boundary, where a key on the last node still hits and an absent key still misses. Random batches of 1 to 16 commands mix bucket starts, mid-chain pointer starts and absent keys. Memory acceptance is random, and responses come back out of order by random slot pick, which exposes tag routing and in-order result release. Result back-pressure is random as well. One full batch without `cmd_last` tests the auto-close.

// File: rtl/lookup_pkg.sv
package lookup_pkg;

    typedef enum logic [1:0] {
        LK_MISS = 2'd0,
        LK_HIT  = 2'd1,
        LK_ERR  = 2'd2
    } lk_status_e;

    typedef enum logic [3:0] {
        W_IDLE,
        W_HEAD_RD,
        W_HEAD_WT,
        W_KEY_RD,
        W_KEY_WT,
        W_VAL_RD,
        W_VAL_WT,
        W_NXT_RD,
        W_NXT_WT,
        W_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        B_FILL,
        B_RUN,
        B_DRAIN
    } batch_state_e;

endpackage

// File: rtl/lookup_walker.sv
module lookup_walker
    import lookup_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int CIDX_W      = 4,
    parameter int MAX_HOPS    = 12,
    parameter int BUCKET_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] st_key,
    input  logic              st_use_ptr,
    input  logic [ADDR_W-1:0] st_loc,
    input  logic [CIDX_W-1:0] st_cidx,
    output logic              idle,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_grant,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              done,
    output logic [CIDX_W-1:0] done_cidx,
    output logic [1:0]        done_status,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] done_value,
    input  logic              done_ack
);

    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    walk_state_e        state_q, state_d;
    logic [DATA_W-1:0]  key_q;
    logic [ADDR_W-1:0]  loc_q;
    logic [ADDR_W-1:0]  cur_q;
    logic [CIDX_W-1:0]  cidx_q;
    logic [HOP_W-1:0]   hops_q;
    lk_status_e         status_q;
    logic [DATA_W-1:0]  value_q;
    logic [ADDR_W-1:0]  rsp_ptr;
    logic               at_limit;

    assign rsp_ptr  = rsp_data[ADDR_W-1:0];
    assign at_limit = (hops_q == HOP_W'(MAX_HOPS));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (start) begin
                    if (!st_use_ptr)         state_d = W_HEAD_RD;
                    else if (st_loc == '0)   state_d = W_DONE;
                    else                     state_d = W_KEY_RD;
                end
            end
            W_HEAD_RD: if (rd_grant) state_d = W_HEAD_WT;
            W_HEAD_WT: begin
                if (rsp_valid) state_d = (rsp_ptr == '0) ? W_DONE : W_KEY_RD;
            end
            W_KEY_RD:  if (rd_grant) state_d = W_KEY_WT;
            W_KEY_WT: begin
                if (rsp_valid) state_d = (rsp_data == key_q) ? W_VAL_RD : W_NXT_RD;
            end
            W_VAL_RD:  if (rd_grant) state_d = W_VAL_WT;
            W_VAL_WT:  if (rsp_valid) state_d = W_DONE;
            W_NXT_RD:  if (rd_grant) state_d = W_NXT_WT;
            W_NXT_WT: begin
                if (rsp_valid) state_d = (rsp_ptr == '0 || at_limit) ? W_DONE : W_KEY_RD;
            end
            W_DONE:    if (done_ack) state_d = W_IDLE;
            default:   state_d = W_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q    <= '0;
            loc_q    <= '0;
            cur_q    <= '0;
            cidx_q   <= '0;
            hops_q   <= '0;
            status_q <= LK_MISS;
            value_q  <= '0;
        end else begin
            if (state_q == W_IDLE && start) begin
                key_q    <= st_key;
                loc_q    <= st_loc;
                cur_q    <= st_loc;
                cidx_q   <= st_cidx;
                hops_q   <= HOP_W'(1);
                status_q <= LK_MISS;
                value_q  <= '0;
            end
            if (state_q == W_HEAD_WT && rsp_valid) cur_q <= rsp_ptr;
            if (state_q == W_KEY_WT && rsp_valid && rsp_data == key_q) status_q <= LK_HIT;
            if (state_q == W_VAL_WT && rsp_valid) value_q <= rsp_data;
            if (state_q == W_NXT_WT && rsp_valid && rsp_ptr != '0) begin
                if (at_limit) begin
                    status_q <= LK_ERR;
                end else begin
                    cur_q  <= rsp_ptr;
                    hops_q <= hops_q + HOP_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        idle        = (state_q == W_IDLE);
        done        = (state_q == W_DONE);
        rd_req      = 1'b0;
        rd_addr     = cur_q;
        unique case (state_q)
            W_HEAD_RD: begin rd_req = 1'b1; rd_addr = ADDR_W'(BUCKET_BASE) + loc_q; end
            W_KEY_RD:  begin rd_req = 1'b1; rd_addr = cur_q; end
            W_VAL_RD:  begin rd_req = 1'b1; rd_addr = cur_q + ADDR_W'(1); end
            W_NXT_RD:  begin rd_req = 1'b1; rd_addr = cur_q + ADDR_W'(2); end
            default:   begin rd_req = 1'b0; rd_addr = cur_q; end
        endcase
        done_cidx   = cidx_q;
        done_status = status_q;
        done_addr   = (status_q == LK_HIT) ? cur_q : '0;
        done_value  = (status_q == LK_HIT) ? value_q : '0;
    end

endmodule

// File: rtl/lookup_mem_arb.sv
module lookup_mem_arb #(
    parameter int NUM_ENG = 4,
    parameter int ADDR_W  = 16,
    parameter int TAG_W   = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_ENG-1:0]             req,
    input  logic [NUM_ENG-1:0][ADDR_W-1:0] req_addr,
    output logic [NUM_ENG-1:0]             grant,
    output logic                           mem_req_valid,
    input  logic                           mem_req_ready,
    output logic [ADDR_W-1:0]              mem_req_addr,
    output logic [TAG_W-1:0]               mem_req_tag
);

    logic [TAG_W-1:0] rr_q;
    logic             held_q;
    logic [TAG_W-1:0] held_id_q;
    logic             found;
    logic [TAG_W-1:0] pick;
    logic [TAG_W-1:0] sel;

    // round-robin search starting at rr_q
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NUM_ENG; i++) begin
            int j;
            j = (int'(rr_q) + i) % NUM_ENG;
            if (!found && req[j]) begin
                found = 1'b1;
                pick  = TAG_W'(j);
            end
        end
    end

    always_comb begin
        sel           = held_q ? held_id_q : pick;
        mem_req_valid = held_q | found;
        mem_req_addr  = req_addr[sel];
        mem_req_tag   = sel;
        grant         = '0;
        if (mem_req_valid && mem_req_ready) grant[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q      <= '0;
            held_q    <= 1'b0;
            held_id_q <= '0;
        end else begin
            held_q    <= mem_req_valid && !mem_req_ready;
            held_id_q <= sel;
            if (mem_req_valid && mem_req_ready)
                rr_q <= (int'(sel) == NUM_ENG - 1) ? '0 : sel + TAG_W'(1);
        end
    end

endmodule

// File: rtl/lookup_batch_ctrl.sv
module lookup_batch_ctrl
    import lookup_pkg::*;
#(
    parameter int NUM_ENG   = 4,
    parameter int BATCH_MAX = 16,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int CIDX_W    = 4,
    parameter int CNT_W     = 5,
    parameter int TAG_W     = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cmd_valid,
    output logic                           cmd_ready,
    input  logic [DATA_W-1:0]              cmd_key,
    input  logic                           cmd_use_ptr,
    input  logic [ADDR_W-1:0]              cmd_loc,
    input  logic                           cmd_last,
    input  logic [NUM_ENG-1:0]             eng_idle,
    output logic [NUM_ENG-1:0]             eng_start,
    output logic [DATA_W-1:0]              disp_key,
    output logic                           disp_use_ptr,
    output logic [ADDR_W-1:0]              disp_loc,
    output logic [CIDX_W-1:0]              disp_cidx,
    input  logic [NUM_ENG-1:0]             eng_done,
    input  logic [NUM_ENG-1:0][CIDX_W-1:0] eng_cidx,
    input  logic [NUM_ENG-1:0][1:0]        eng_status,
    input  logic [NUM_ENG-1:0][ADDR_W-1:0] eng_addr,
    input  logic [NUM_ENG-1:0][DATA_W-1:0] eng_value,
    output logic [NUM_ENG-1:0]             eng_ack,
    output logic                           res_valid,
    input  logic                           res_ready,
    output logic [CIDX_W-1:0]              res_idx,
    output logic [1:0]                     res_status,
    output logic [ADDR_W-1:0]              res_addr,
    output logic [DATA_W-1:0]              res_value,
    output logic                           res_last
);

    batch_state_e state_q, state_d;

    logic [DATA_W-1:0] cb_key  [BATCH_MAX];
    logic              cb_ptr  [BATCH_MAX];
    logic [ADDR_W-1:0] cb_loc  [BATCH_MAX];
    logic [1:0]        rb_stat [BATCH_MAX];
    logic [ADDR_W-1:0] rb_addr [BATCH_MAX];
    logic [DATA_W-1:0] rb_val  [BATCH_MAX];

    logic [CNT_W-1:0] count_q, disp_q, fin_q, out_q;
    logic             any_idle, any_done, disp_ok, take_cmd, take_res, final_res;
    logic [TAG_W-1:0] idle_sel, done_sel;

    // lowest-numbered idle and done engines
    always_comb begin
        any_idle = 1'b0;
        idle_sel = '0;
        any_done = 1'b0;
        done_sel = '0;
        for (int i = NUM_ENG - 1; i >= 0; i--) begin
            if (eng_idle[i]) begin any_idle = 1'b1; idle_sel = TAG_W'(i); end
            if (eng_done[i]) begin any_done = 1'b1; done_sel = TAG_W'(i); end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= B_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_FILL:  if (cmd_valid && (cmd_last || count_q == CNT_W'(BATCH_MAX - 1))) state_d = B_RUN;
            B_RUN:   if (fin_q == count_q) state_d = B_DRAIN;
            B_DRAIN: if (res_ready && final_res) state_d = B_FILL;
            default: state_d = B_FILL;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready    = (state_q == B_FILL);
        take_cmd     = cmd_ready && cmd_valid;
        disp_ok      = (state_q == B_RUN) && (disp_q < count_q) && any_idle;
        eng_start    = '0;
        if (disp_ok) eng_start[idle_sel] = 1'b1;
        disp_key     = cb_key[disp_q[CIDX_W-1:0]];
        disp_use_ptr = cb_ptr[disp_q[CIDX_W-1:0]];
        disp_loc     = cb_loc[disp_q[CIDX_W-1:0]];
        disp_cidx    = disp_q[CIDX_W-1:0];
        eng_ack      = '0;
        if (state_q == B_RUN && any_done) eng_ack[done_sel] = 1'b1;
        res_valid    = (state_q == B_DRAIN);
        final_res    = (out_q == count_q - CNT_W'(1));
        take_res     = res_valid && res_ready;
        res_idx      = out_q[CIDX_W-1:0];
        res_status   = rb_stat[out_q[CIDX_W-1:0]];
        res_addr     = rb_addr[out_q[CIDX_W-1:0]];
        res_value    = rb_val[out_q[CIDX_W-1:0]];
        res_last     = final_res;
    end

    // buffers
    always_ff @(posedge clk) begin
        if (take_cmd) begin
            cb_key[count_q[CIDX_W-1:0]] <= cmd_key;
            cb_ptr[count_q[CIDX_W-1:0]] <= cmd_use_ptr;
            cb_loc[count_q[CIDX_W-1:0]] <= cmd_loc;
        end
        if (state_q == B_RUN && any_done) begin
            rb_stat[eng_cidx[done_sel]] <= eng_status[done_sel];
            rb_addr[eng_cidx[done_sel]] <= eng_addr[done_sel];
            rb_val[eng_cidx[done_sel]]  <= eng_value[done_sel];
        end
    end

    // counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            disp_q  <= '0;
            fin_q   <= '0;
            out_q   <= '0;
        end else begin
            if (take_cmd) count_q <= count_q + CNT_W'(1);
            if (disp_ok) disp_q <= disp_q + CNT_W'(1);
            if (state_q == B_RUN && any_done) fin_q <= fin_q + CNT_W'(1);
            if (take_res) begin
                if (final_res) begin
                    count_q <= '0;
                    disp_q  <= '0;
                    fin_q   <= '0;
                    out_q   <= '0;
                end else begin
                    out_q <= out_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/chain_lookup_top.sv
module chain_lookup_top
    import lookup_pkg::*;
#(
    parameter int NUM_ENG     = 4,
    parameter int BATCH_MAX   = 16,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int MAX_HOPS    = 12,
    parameter int BUCKET_BASE = 256,
    localparam int TAG_W      = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
    localparam int CIDX_W     = (BATCH_MAX > 1) ? $clog2(BATCH_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_key,
    input  logic              cmd_use_ptr,
    input  logic [ADDR_W-1:0] cmd_loc,
    input  logic              cmd_last,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [CIDX_W-1:0] res_idx,
    output logic [1:0]        res_status,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_value,
    output logic              res_last
);

    localparam int CNT_W = $clog2(BATCH_MAX + 1);

    logic [NUM_ENG-1:0]             eng_idle, eng_start, eng_done, eng_ack;
    logic [NUM_ENG-1:0]             eng_req, eng_grant;
    logic [NUM_ENG-1:0][ADDR_W-1:0] eng_rd_addr;
    logic [NUM_ENG-1:0][CIDX_W-1:0] eng_cidx;
    logic [NUM_ENG-1:0][1:0]        eng_status;
    logic [NUM_ENG-1:0][ADDR_W-1:0] eng_addr;
    logic [NUM_ENG-1:0][DATA_W-1:0] eng_value;
    logic [DATA_W-1:0]              disp_key;
    logic                           disp_use_ptr;
    logic [ADDR_W-1:0]              disp_loc;
    logic [CIDX_W-1:0]              disp_cidx;

    lookup_batch_ctrl #(
        .NUM_ENG(NUM_ENG), .BATCH_MAX(BATCH_MAX), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CIDX_W(CIDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W)
    ) ctrl_i (
        .clk, .rst_n,
        .cmd_valid, .cmd_ready, .cmd_key, .cmd_use_ptr, .cmd_loc, .cmd_last,
        .eng_idle, .eng_start, .disp_key, .disp_use_ptr, .disp_loc, .disp_cidx,
        .eng_done, .eng_cidx, .eng_status, .eng_addr, .eng_value, .eng_ack,
        .res_valid, .res_ready, .res_idx, .res_status, .res_addr, .res_value, .res_last
    );

    lookup_mem_arb #(
        .NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) arb_i (
        .clk, .rst_n,
        .req(eng_req), .req_addr(eng_rd_addr), .grant(eng_grant),
        .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_tag
    );

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic rsp_hit;
        assign rsp_hit = mem_rsp_valid && (mem_rsp_tag == TAG_W'(e));

        lookup_walker #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CIDX_W(CIDX_W),
            .MAX_HOPS(MAX_HOPS), .BUCKET_BASE(BUCKET_BASE)
        ) walker_i (
            .clk, .rst_n,
            .start(eng_start[e]), .st_key(disp_key), .st_use_ptr(disp_use_ptr),
            .st_loc(disp_loc), .st_cidx(disp_cidx), .idle(eng_idle[e]),
            .rd_req(eng_req[e]), .rd_addr(eng_rd_addr[e]), .rd_grant(eng_grant[e]),
            .rsp_valid(rsp_hit), .rsp_data(mem_rsp_data),
            .done(eng_done[e]), .done_cidx(eng_cidx[e]), .done_status(eng_status[e]),
            .done_addr(eng_addr[e]), .done_value(eng_value[e]), .done_ack(eng_ack[e])
        );
    end

endmodule

// File: rtl/lookup_checker.sv
module lookup_checker #(
    parameter int NUM_ENG = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 2,
    parameter int CIDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [TAG_W-1:0]  mem_req_tag,
    input logic              mem_rsp_valid,
    input logic [TAG_W-1:0]  mem_rsp_tag,
    input logic              res_valid,
    input logic              res_ready,
    input logic [CIDX_W-1:0] res_idx,
    input logic [1:0]        res_status,
    input logic [ADDR_W-1:0] res_addr,
    input logic [DATA_W-1:0] res_value
);

    logic [NUM_ENG-1:0] pend_q;
    logic               req_tag_busy, rsp_tag_busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_ENG; i++) begin
                if (mem_req_valid && mem_req_ready && mem_req_tag == TAG_W'(i)) pend_q[i] <= 1'b1;
                else if (mem_rsp_valid && mem_rsp_tag == TAG_W'(i))             pend_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        req_tag_busy = 1'b0;
        rsp_tag_busy = 1'b0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (mem_req_tag == TAG_W'(i) && pend_q[i]) req_tag_busy = 1'b1;
            if (mem_rsp_tag == TAG_W'(i) && pend_q[i]) rsp_tag_busy = 1'b1;
        end
    end

    AST_ONE_READ_PER_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |-> !req_tag_busy); // R8
    AST_RSP_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> rsp_tag_busy); // R8
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag))); // R10
    AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !cmd_ready); // R2
    AST_RES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_idx) && $stable(res_value) && $stable(res_status))); // R9
    AST_NO_READS_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (!mem_req_valid && pend_q == '0)); // R9
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_status != 2'd3)); // R5
    AST_HIT_NONNULL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == 2'd1) |-> (res_addr != '0)); // R5
    AST_NONHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != 2'd1) |-> (res_addr == '0 && res_value == '0)); // R6

endmodule

bind chain_lookup_top lookup_checker #(
    .NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .CIDX_W(CIDX_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .res_valid(res_valid), .res_ready(res_ready), .res_idx(res_idx),
    .res_status(res_status), .res_addr(res_addr), .res_value(res_value)
);

// File: tb/chain_lookup_top_tb_top.sv
`timescale 1ns/1ps
module chain_lookup_top_tb_top;

    localparam int NE = 4;
    localparam int BM = 16;
    localparam int MH = 12;
    localparam int BB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_use_ptr = 1'b0, cmd_last = 1'b0;
    logic [31:0] cmd_key = '0;
    logic [15:0] cmd_loc = '0;
    logic        cmd_ready;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [15:0] mem_req_addr;
    logic [1:0]  mem_req_tag;
    logic        mem_rsp_valid = 1'b0;
    logic [1:0]  mem_rsp_tag = '0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_ready = 1'b0, res_last;
    logic [3:0]  res_idx;
    logic [1:0]  res_status;
    logic [15:0] res_addr;
    logic [31:0] res_value;

    always #2.5 clk = ~clk;

    chain_lookup_top #(.NUM_ENG(NE), .BATCH_MAX(BM), .MAX_HOPS(MH), .BUCKET_BASE(BB)) dut_i (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_key, .cmd_use_ptr, .cmd_loc, .cmd_last,
        .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_req_tag,
        .mem_rsp_valid, .mem_rsp_tag, .mem_rsp_data,
        .res_valid, .res_ready, .res_idx, .res_status, .res_addr, .res_value, .res_last
    );

    int n_cmp = 0, n_bad = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] node_key [0:127];
    logic [15:0] node_adr [0:127];
    logic [3:0]  node_bkt [0:127];
    int          n_nodes = 0;

    // memory model state
    bit          pv [0:7];
    logic [15:0] pa [0:7];
    logic [1:0]  pt [0:7];
    int          outst = 0, req_total = 0;
    logic [15:0] addr_log [0:63];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] key, input bit up, input logic [15:0] loc,
                                  output logic [1:0] st, output logic [15:0] a, output logic [31:0] v);
        logic [15:0] p, nx;
        int hops;
        st = 2'd0; a = '0; v = '0;
        p = up ? loc : mem[(BB + loc) % 1024][15:0];
        if (p == 0) return;
        hops = 1;
        for (int g = 0; g < 1000; g++) begin
            if (mem[p[9:0]] == key) begin st = 2'd1; a = p; v = mem[p[9:0] + 1]; return; end
            nx = mem[p[9:0] + 2][15:0];
            if (nx == 0) return;
            if (hops == MH) begin st = 2'd2; return; end
            p = nx;
            hops++;
        end
    endfunction

    // memory responder: random acceptance, out-of-order return
    always @(negedge clk) begin
        int cand [0:7];
        int nc;
        if (rst_n) begin
            nc = 0;
            for (int s = 0; s < 8; s++) if (pv[s]) begin cand[nc] = s; nc++; end
            if (nc > 0 && ($urandom % 2) == 0) begin
                int s;
                s = cand[$urandom % nc];
                mem_rsp_valid <= 1'b1;
                mem_rsp_tag   <= pt[s];
                mem_rsp_data  <= mem[pa[s][9:0]];
                pv[s] = 1'b0;
                outst--;
            end else begin
                mem_rsp_valid <= 1'b0;
            end
            mem_req_ready <= (($urandom % 4) != 0);
            #1;
            if (mem_req_valid && mem_req_ready) begin
                for (int s = 0; s < 8; s++) begin
                    if (!pv[s]) begin
                        pv[s] = 1'b1; pa[s] = mem_req_addr; pt[s] = mem_req_tag;
                        break;
                    end
                end
                addr_log[req_total % 64] = mem_req_addr;
                req_total++;
                outst++;
            end
        end
    end

    logic [31:0] bk [0:15];
    bit          bp [0:15];
    logic [15:0] bl [0:15];

    task automatic run_batch(input int n, input bit close_last);
        logic [1:0]  es [0:15];
        logic [15:0] ea [0:15];
        logic [31:0] ev [0:15];
        int k;
        bit first;
        for (int i = 0; i < n; i++) model(bk[i], bp[i], bl[i], es[i], ea[i], ev[i]);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_key = bk[i]; cmd_use_ptr = bp[i]; cmd_loc = bl[i];
            cmd_last = close_last && (i == n - 1);
            #1;
            while (!cmd_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_last = 1'b0;
        #1;
        chk(!cmd_ready, "R2", "cmd_ready after close", 64'(cmd_ready), 64'd0);
        k = 0; first = 1'b1;
        while (k < n) begin
            @(negedge clk);
            res_ready = (($urandom % 4) != 0);
            #1;
            if (res_valid && res_ready) begin
                if (first) begin
                    chk(outst == 0, "R9", "reads pending at first result", 64'(outst), 64'd0);
                    first = 1'b0;
                end
                chk(res_idx == 4'(k), "R9", "index order", 64'(res_idx), 64'(k));
                chk(res_last == (k == n - 1), "R9", "last flag", 64'(res_last), 64'(k == n - 1));
                chk(res_status == es[k], "R5/R6/R7", "status", 64'(res_status), 64'(es[k]));
                chk(res_addr == ea[k], "R5", "node address", 64'(res_addr), 64'(ea[k]));
                chk(res_value == ev[k], "R5", "value", 64'(res_value), 64'(ev[k]));
                k++;
            end
        end
        @(negedge clk);
        res_ready = 1'b0;
        #1;
        chk(cmd_ready, "R1", "cmd_ready after drain", 64'(cmd_ready), 64'd1);
        chk(!res_valid, "R9", "res_valid after drain", 64'(res_valid), 64'd0);
    endtask

    task automatic add_node(input logic [31:0] key, input logic [3:0] b, output logic [15:0] a);
        a = 16'(512 + 4 * n_nodes);
        mem[a[9:0]] = key; mem[a[9:0] + 1] = $urandom; mem[a[9:0] + 2] = 32'd0;
        node_key[n_nodes] = key; node_adr[n_nodes] = a; node_bkt[n_nodes] = b;
        n_nodes++;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] a, prev, c0, last_a;
        int base;
        logic [31:0] last_key;
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
        for (int s = 0; s < 8; s++) pv[s] = 1'b0;
        // buckets 0..12 random short chains, 13 empty
        for (int b = 0; b < 13; b++) begin
            int len;
            len = 1 + ($urandom % 4);
            prev = 0;
            for (int j = 0; j < len; j++) begin
                add_node({8'(b), 8'(j), 16'($urandom)}, 4'(b), a);
                if (j == 0) mem[BB + b] = 32'(a); else mem[prev[9:0] + 2] = 32'(a);
                prev = a;
            end
        end
        // bucket 14: three-node loop
        add_node(32'hC0C0_0001, 4'd14, c0); mem[BB + 14] = 32'(c0);
        add_node(32'hC0C0_0002, 4'd14, a);  mem[c0[9:0] + 2] = 32'(a); prev = a;
        add_node(32'hC0C0_0003, 4'd14, a);  mem[prev[9:0] + 2] = 32'(a);
        mem[a[9:0] + 2] = 32'(c0);
        // bucket 15: chain of exactly MH nodes
        prev = 0;
        for (int j = 0; j < MH; j++) begin
            add_node({8'hF0, 8'(j), 16'h5A5A}, 4'd15, a);
            if (j == 0) mem[BB + 15] = 32'(a); else mem[prev[9:0] + 2] = 32'(a);
            prev = a;
        end
        last_a = a; last_key = mem[a[9:0]];

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cmd_ready, "R1", "reset cmd_ready", 64'(cmd_ready), 64'd1);
        chk(!res_valid, "R9", "reset res_valid", 64'(res_valid), 64'd0);
        chk(!mem_req_valid, "R10", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        // R3: bucket head hit, first read at bucket slot
        bk[0] = mem[mem[BB + 3][9:0]]; bp[0] = 1'b0; bl[0] = 16'd3;
        base = req_total;
        run_batch(1, 1'b1);
        chk(addr_log[base % 64] == 16'(BB + 3), "R3", "first read address",
            64'(addr_log[base % 64]), 64'(BB + 3));
        // R3: empty bucket gives miss after one read
        bk[0] = 32'h1234_5678; bp[0] = 1'b0; bl[0] = 16'd13;
        base = req_total;
        run_batch(1, 1'b1);
        chk(req_total - base == 1, "R3", "reads for empty bucket", 64'(req_total - base), 64'd1);
        // R4: null pointer start, no reads
        bk[0] = 32'h0; bp[0] = 1'b1; bl[0] = 16'd0;
        base = req_total;
        run_batch(1, 1'b1);
        chk(req_total == base, "R4", "reads for null start", 64'(req_total - base), 64'd0);
        // R7: loop ends in error; R6 miss at end of long chain; R7 hit at limit
        bk[0] = 32'hDEAD_0000; bp[0] = 1'b0; bl[0] = 16'd14;
        bk[1] = 32'hDEAD_0001; bp[1] = 1'b0; bl[1] = 16'd15;
        bk[2] = last_key;      bp[2] = 1'b0; bl[2] = 16'd15;
        bk[3] = last_key;      bp[3] = 1'b1; bl[3] = last_a;
        run_batch(4, 1'b1);
        // R1: full batch closes without cmd_last
        for (int i = 0; i < 16; i++) begin
            int q;
            q = $urandom % n_nodes;
            bk[i] = node_key[q]; bp[i] = i[0]; bl[i] = i[0] ? node_adr[q] : 16'(node_bkt[q]);
        end
        run_batch(16, 1'b0);
        // random batches
        for (int r = 0; r < 25; r++) begin
            int n;
            n = 1 + ($urandom % 16);
            for (int i = 0; i < n; i++) begin
                int q, m;
                q = $urandom % n_nodes;
                m = $urandom % 5;
                if (m < 2)       begin bk[i] = node_key[q]; bp[i] = 1'b0; bl[i] = 16'(node_bkt[q]); end
                else if (m == 2) begin bk[i] = node_key[$urandom % n_nodes]; bp[i] = 1'b1; bl[i] = node_adr[q]; end
                else             begin bk[i] = $urandom; bp[i] = 1'b0; bl[i] = 16'($urandom % 16); end
            end
            run_batch(n, 1'b1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule